// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt sources and drives two request lines toward a processor. One is a normal request line, the other a fast request line. Each source has a route bit that chooses its line. Each source also has an enable bit, a software force bit and a 4-bit priority. A normal-priority threshold can block low-ranked normal sources.

Software reaches every setting through a simple word-wide register port. Writes take effect at the clock edge. Reads return data in the same cycle. Two vector words tell the handler which source to service. The normal vector word gives the number and priority of the highest-ranked pending normal source, or all ones in its upper half when none is pending. The handler can keep reading it until it sees that all-ones value. The fast vector word gives the lowest-numbered pending fast source.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the following read as zero: enable, route, force and control words, and every priority field. The normal-priority threshold reads 0x1F. Both vector words read 0xFFFF0000. Both request lines are low.
- R2: A source is pending when its sampled input or its force bit is 1 and its enable bit is 1. A pending source with route bit 0 appears in the normal pending words (0x58 = sources 32–63, 0x5C = sources 0–31), subject to R7. A pending source with route bit 1 appears in the fast pending words (0x60 high, 0x64 low). Source n sits at bit n%32 of its word.
- R3: Enable words sit at 0x10 (sources 32–63) and 0x14 (sources 0–31). Route words sit at 0x18 and 0x1C with the same split. Force words sit at 0x50 and 0x54 with the same split. All of these read back what was written.
- R4: Writing to 0x08 sets the enable bit of the source numbered by wdata[5:0]. Writing to 0x0C clears it. Both addresses read as zero.
- R5: Priority group k holds sources 8k..8k+7 and sits at byte offset 0x20 + 4*(7-k). Source n uses bits [4*(n%8)+3 : 4*(n%8)] of its group word.
- R6: Normal vector word (0x40): bits [31:16] hold the pending normal source with the highest priority, and ties go to the higher source number. Bits [15:0] hold that source's priority. With nothing pending the word is 0xFFFF0000.
- R7: Normal-priority threshold (0x04, 5 bits). If bit 4 is 1, no source is blocked. Otherwise a normal source whose priority is at or below bits [3:0] is not pending.
- R8: Fast vector word (0x44): bits [31:16] hold the lowest-numbered pending fast source, or 0xFFFF when none is pending. Bits [15:0] are zero.
- R9: nirq_o is 1 exactly when some normal source is pending. firq_o is 1 exactly when some fast source is pending.
- R10: Source inputs are registered. A change on irq_src_i shows up in the status words and request lines after the next rising edge, not before.
- R11: The control word (0x00) stores and returns all 32 bits. It has no other effect. The source words (0x48 high, 0x4C low) return the sampled inputs.
- R12: An access whose byte address has a nonzero bits [1:0], or that targets an unmapped word, reads zero and is ignored on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | 64 | Level-sensitive source inputs |
| bus_wr_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | 7 | Byte address of the accessed register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, same cycle |
| nirq_o | output | 1 | Normal interrupt request |
| firq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default sizes: 64 sources in two 32-bit halves and 4-bit priorities in eight group words. This puts the reversed placement of the priority groups within reach. It also covers the split between the high and low words and the full range of by-number enable indices. Directed steps cover priority ties across the two halves, each threshold boundary, and fast-versus-normal routing of the same source. A long random phase then mixes register writes with changing inputs while the model follows along.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int NSRC    = 64;
    localparam int PRIO_W  = 4;
    localparam int IDX_W   = $clog2(NSRC);
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int WIDX_W  = ADDR_W - 2;
    localparam int THR_W   = PRIO_W + 1;

    localparam logic [WIDX_W-1:0] W_CTRL  = 5'd0;
    localparam logic [WIDX_W-1:0] W_THR   = 5'd1;
    localparam logic [WIDX_W-1:0] W_ENNUM = 5'd2;
    localparam logic [WIDX_W-1:0] W_DISN  = 5'd3;
    localparam logic [WIDX_W-1:0] W_ENH   = 5'd4;
    localparam logic [WIDX_W-1:0] W_ENL   = 5'd5;
    localparam logic [WIDX_W-1:0] W_RTH   = 5'd6;
    localparam logic [WIDX_W-1:0] W_RTL   = 5'd7;
    localparam logic [WIDX_W-1:0] W_NVEC  = 5'd16;
    localparam logic [WIDX_W-1:0] W_FVEC  = 5'd17;
    localparam logic [WIDX_W-1:0] W_SRCH  = 5'd18;
    localparam logic [WIDX_W-1:0] W_SRCL  = 5'd19;
    localparam logic [WIDX_W-1:0] W_FRCH  = 5'd20;
    localparam logic [WIDX_W-1:0] W_FRCL  = 5'd21;
    localparam logic [WIDX_W-1:0] W_NPH   = 5'd22;
    localparam logic [WIDX_W-1:0] W_NPL   = 5'd23;
    localparam logic [WIDX_W-1:0] W_FPH   = 5'd24;
    localparam logic [WIDX_W-1:0] W_FPL   = 5'd25;
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
    import irqv_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int PW = PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [WIDX_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [N-1:0]      en_q,
    output logic [N-1:0]      ty_q,
    output logic [N-1:0]      frc_q,
    output logic [N*PW-1:0]   prio_q,
    output logic [THR_W-1:0]  thr_q,
    output logic [DATA_W-1:0] ctrl_q
);
    localparam int HALF = N / 2;

    logic [2:0] grp;
    assign grp = ~widx[2:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            ty_q   <= '0;
            frc_q  <= '0;
            prio_q <= '0;
            thr_q  <= '1;
            ctrl_q <= '0;
        end else if (wr_ok) begin
            case (widx)
                W_CTRL:  ctrl_q <= wdata;
                W_THR:   thr_q  <= wdata[THR_W-1:0];
                W_ENNUM: en_q[wdata[IDX_W-1:0]] <= 1'b1;
                W_DISN:  en_q[wdata[IDX_W-1:0]] <= 1'b0;
                W_ENH:   en_q[N-1:HALF]  <= wdata;
                W_ENL:   en_q[HALF-1:0]  <= wdata;
                W_RTH:   ty_q[N-1:HALF]  <= wdata;
                W_RTL:   ty_q[HALF-1:0]  <= wdata;
                W_FRCH:  frc_q[N-1:HALF] <= wdata;
                W_FRCL:  frc_q[HALF-1:0] <= wdata;
                default: begin
                    if (widx[4:3] == 2'b01)
                        prio_q[DATA_W*grp +: DATA_W] <= wdata;
                end
            endcase
        end
    end
endmodule

// File: rtl/irqv_pend.sv
module irqv_pend
    import irqv_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int PW = PRIO_W
) (
    input  logic [N-1:0]     src_q,
    input  logic [N-1:0]     en_q,
    input  logic [N-1:0]     ty_q,
    input  logic [N-1:0]     frc_q,
    input  logic [N*PW-1:0]  prio_q,
    input  logic [PW:0]      thr_q,
    output logic [N-1:0]     npend,
    output logic [N-1:0]     fpend
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic live;
        logic above;
        assign live     = (src_q[i] | frc_q[i]) & en_q[i];
        assign above    = thr_q[PW] | (prio_q[i*PW +: PW] > thr_q[PW-1:0]);
        assign npend[i] = live & ~ty_q[i] & above;
        assign fpend[i] = live & ty_q[i];
    end
endmodule

// File: rtl/irqv_nsel.sv
module irqv_nsel
    import irqv_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int PW = PRIO_W,
    parameter int IW = IDX_W
) (
    input  logic [N-1:0]    npend,
    input  logic [N*PW-1:0] prio_q,
    output logic            found,
    output logic [IW-1:0]   num,
    output logic [PW-1:0]   best
);
    always_comb begin
        found = 1'b0;
        num   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (npend[i] && (!found || prio_q[i*PW +: PW] >= best)) begin
                found = 1'b1;
                best  = prio_q[i*PW +: PW];
                num   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqv_fsel.sv
module irqv_fsel
    import irqv_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int IW = IDX_W
) (
    input  logic [N-1:0]  fpend,
    output logic          found,
    output logic [IW-1:0] num
);
    always_comb begin
        found = 1'b0;
        num   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (fpend[i]) begin
                found = 1'b1;
                num   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              nirq_o,
    output logic              firq_o
);
    localparam int HALF = NSRC / 2;
    localparam int VH   = DATA_W / 2;

    logic [WIDX_W-1:0]     widx;
    logic                  aligned;
    logic                  wr_ok;
    logic [NSRC-1:0]       src_q;
    logic [NSRC-1:0]       en_q;
    logic [NSRC-1:0]       ty_q;
    logic [NSRC-1:0]       frc_q;
    logic [NSRC*PRIO_W-1:0] prio_q;
    logic [THR_W-1:0]      thr_q;
    logic [DATA_W-1:0]     ctrl_q;
    logic [NSRC-1:0]       npend;
    logic [NSRC-1:0]       fpend;
    logic                  nwin_found;
    logic [IDX_W-1:0]      nwin_num;
    logic [PRIO_W-1:0]     nwin_prio;
    logic                  fwin_found;
    logic [IDX_W-1:0]      fwin_num;
    logic [DATA_W-1:0]     nvec;
    logic [DATA_W-1:0]     fvec;
    logic [2:0]            grp;

    assign widx    = bus_addr_i[ADDR_W-1:2];
    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign wr_ok   = bus_wr_i & aligned;
    assign grp     = ~widx[2:0];

    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= irq_src_i;
    end

    irqv_regs #(.N(NSRC), .PW(PRIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .widx(widx), .wdata(bus_wdata_i),
        .en_q(en_q), .ty_q(ty_q), .frc_q(frc_q), .prio_q(prio_q),
        .thr_q(thr_q), .ctrl_q(ctrl_q)
    );

    irqv_pend #(.N(NSRC), .PW(PRIO_W)) u_pend (
        .src_q(src_q), .en_q(en_q), .ty_q(ty_q), .frc_q(frc_q),
        .prio_q(prio_q), .thr_q(thr_q), .npend(npend), .fpend(fpend)
    );

    irqv_nsel #(.N(NSRC), .PW(PRIO_W), .IW(IDX_W)) u_nsel (
        .npend(npend), .prio_q(prio_q),
        .found(nwin_found), .num(nwin_num), .best(nwin_prio)
    );

    irqv_fsel #(.N(NSRC), .IW(IDX_W)) u_fsel (
        .fpend(fpend), .found(fwin_found), .num(fwin_num)
    );

    assign nvec = nwin_found ? {VH'(nwin_num), VH'(nwin_prio)} : {{VH{1'b1}}, {VH{1'b0}}};
    assign fvec = fwin_found ? {VH'(fwin_num), {VH{1'b0}}}     : {{VH{1'b1}}, {VH{1'b0}}};

    assign nirq_o = |npend;
    assign firq_o = |fpend;

    always_comb begin
        bus_rdata_o = '0;
        if (aligned) begin
            case (widx)
                W_CTRL:  bus_rdata_o = ctrl_q;
                W_THR:   bus_rdata_o = DATA_W'(thr_q);
                W_ENH:   bus_rdata_o = en_q[NSRC-1:HALF];
                W_ENL:   bus_rdata_o = en_q[HALF-1:0];
                W_RTH:   bus_rdata_o = ty_q[NSRC-1:HALF];
                W_RTL:   bus_rdata_o = ty_q[HALF-1:0];
                W_NVEC:  bus_rdata_o = nvec;
                W_FVEC:  bus_rdata_o = fvec;
                W_SRCH:  bus_rdata_o = src_q[NSRC-1:HALF];
                W_SRCL:  bus_rdata_o = src_q[HALF-1:0];
                W_FRCH:  bus_rdata_o = frc_q[NSRC-1:HALF];
                W_FRCL:  bus_rdata_o = frc_q[HALF-1:0];
                W_NPH:   bus_rdata_o = npend[NSRC-1:HALF];
                W_NPL:   bus_rdata_o = npend[HALF-1:0];
                W_FPH:   bus_rdata_o = fpend[NSRC-1:HALF];
                W_FPL:   bus_rdata_o = fpend[HALF-1:0];
                default: begin
                    if (widx[4:3] == 2'b01)
                        bus_rdata_o = prio_q[DATA_W*grp +: DATA_W];
                end
            endcase
        end
    end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
    import irqv_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              nirq_o,
    input logic              firq_o,
    input logic [NSRC-1:0]   npend,
    input logic [NSRC-1:0]   fpend,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   ty_q,
    input logic              nwin_found,
    input logic [IDX_W-1:0]  nwin_num,
    input logic              fwin_found,
    input logic [IDX_W-1:0]  fwin_num,
    input logic              wr_ok,
    input logic [WIDX_W-1:0] widx,
    input logic [DATA_W-1:0] bus_wdata_i
);
    logic [NSRC-1:0] below_fwin;
    assign below_fwin = (NSRC'(1) << fwin_num) - NSRC'(1);

    AST_NIRQ_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        nirq_o == nwin_found);                                        // R9
    AST_FIRQ_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        firq_o == fwin_found);                                        // R9
    AST_NWIN_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        nwin_found |-> (en_q[nwin_num] && !ty_q[nwin_num] && npend[nwin_num])); // R2
    AST_FWIN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        fwin_found |-> (fpend[fwin_num] && ((fpend & below_fwin) == '0)));      // R8
    AST_ENNUM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && widx == W_ENNUM) |=> en_q[$past(bus_wdata_i[IDX_W-1:0])]);   // R4
    AST_DISNUM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && widx == W_DISN) |=> !en_q[$past(bus_wdata_i[IDX_W-1:0])]);   // R4
    AST_PEND_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (npend & fpend) == '0);                                       // R2
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .nirq_o(nirq_o), .firq_o(firq_o),
    .npend(npend), .fpend(fpend), .en_q(en_q), .ty_q(ty_q),
    .nwin_found(nwin_found), .nwin_num(nwin_num),
    .fwin_found(fwin_found), .fwin_num(fwin_num),
    .wr_ok(wr_ok), .widx(widx), .bus_wdata_i(bus_wdata_i)
);

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] src;
    logic        wr_en;
    logic [6:0]  addr;
    logic [31:0] wdata;
    wire  [31:0] rdata;
    wire         nirq;
    wire         firq;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_vec_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src), .bus_wr_i(wr_en),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .nirq_o(nirq), .firq_o(firq)
    );

    // behavioural reference state
    logic [63:0] m_en, m_ty, m_frc, m_src;
    logic [3:0]  m_pr [64];
    logic [4:0]  m_thr;
    logic [31:0] m_ctl;

    function automatic void m_reset();
        m_en = '0; m_ty = '0; m_frc = '0; m_src = '0; m_thr = 5'h1F; m_ctl = '0;
        for (int i = 0; i < 64; i++) m_pr[i] = 4'h0;
    endfunction

    function automatic bit m_np(int s);
        bit live = (m_src[s] | m_frc[s]) & m_en[s];
        return live && !m_ty[s] && (m_thr[4] || (m_pr[s] > m_thr[3:0]));
    endfunction

    function automatic bit m_fp(int s);
        return (m_src[s] | m_frc[s]) & m_en[s] & m_ty[s];
    endfunction

    function automatic logic [31:0] m_nvec();
        for (int p = 15; p >= 0; p--)
            for (int s = 63; s >= 0; s--)
                if (m_np(s) && m_pr[s] == p) return {16'(s), 16'(p)};
        return 32'hFFFF_0000;
    endfunction

    function automatic logic [31:0] m_fvec();
        for (int s = 0; s < 64; s++)
            if (m_fp(s)) return {16'(s), 16'h0};
        return 32'hFFFF_0000;
    endfunction

    function automatic logic [31:0] m_word(int kind, int base);
        logic [31:0] w = '0;
        for (int b = 0; b < 32; b++)
            w[b] = (kind == 0) ? m_np(base + b) : m_fp(base + b);
        return w;
    endfunction

    function automatic logic [31:0] m_read(logic [6:0] a);
        logic [31:0] w = '0;
        if (a[1:0] != 2'b00) return '0;
        if (a >= 7'h20 && a <= 7'h3C) begin
            int k = 7 - ((int'(a) - 32) / 4);
            for (int j = 0; j < 8; j++) w[4*j +: 4] = m_pr[8*k + j];
            return w;
        end
        case (a)
            7'h00: return m_ctl;
            7'h04: return {27'h0, m_thr};
            7'h10: return m_en[63:32];
            7'h14: return m_en[31:0];
            7'h18: return m_ty[63:32];
            7'h1C: return m_ty[31:0];
            7'h40: return m_nvec();
            7'h44: return m_fvec();
            7'h48: return m_src[63:32];
            7'h4C: return m_src[31:0];
            7'h50: return m_frc[63:32];
            7'h54: return m_frc[31:0];
            7'h58: return m_word(0, 32);
            7'h5C: return m_word(0, 0);
            7'h60: return m_word(1, 32);
            7'h64: return m_word(1, 0);
            default: return '0;
        endcase
    endfunction

    function automatic void m_write(logic [6:0] a, logic [31:0] d);
        if (a[1:0] != 2'b00) return;
        if (a >= 7'h20 && a <= 7'h3C) begin
            int k = 7 - ((int'(a) - 32) / 4);
            for (int j = 0; j < 8; j++) m_pr[8*k + j] = d[4*j +: 4];
            return;
        end
        case (a)
            7'h00: m_ctl = d;
            7'h04: m_thr = d[4:0];
            7'h08: m_en[d[5:0]] = 1'b1;
            7'h0C: m_en[d[5:0]] = 1'b0;
            7'h10: m_en[63:32] = d;
            7'h14: m_en[31:0] = d;
            7'h18: m_ty[63:32] = d;
            7'h1C: m_ty[31:0] = d;
            7'h50: m_frc[63:32] = d;
            7'h54: m_frc[31:0] = d;
            default: ;
        endcase
    endfunction

    function automatic bit m_nirq();
        for (int s = 0; s < 64; s++) if (m_np(s)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit m_firq();
        for (int s = 0; s < 64; s++) if (m_fp(s)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: capture driven inputs, advance model after the edge, compare outputs
    task automatic tick();
        logic        w  = wr_en;
        logic [6:0]  a  = addr;
        logic [31:0] d  = wdata;
        logic [63:0] s  = src;
        @(posedge clk);
        #1;
        if (w) m_write(a, d);
        m_src = s;
        check("R9 nirq", 32'(nirq), 32'(m_nirq()));
        check("R9 firq", 32'(firq), 32'(m_firq()));
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(string req, logic [6:0] a);
        addr = a;
        #1;
        check(req, rdata, m_read(a));
    endtask

    task automatic rd_lit(string req, logic [6:0] a, logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
        check({req, " model"}, rdata, m_read(a));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src = '0; wr_en = 1'b0; addr = '0; wdata = '0;
        m_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        check("R1 nirq", 32'(nirq), 32'd0);
        check("R1 firq", 32'(firq), 32'd0);
        rd_lit("R1 threshold", 7'h04, 32'h0000_001F);
        rd_lit("R1 nvec", 7'h40, 32'hFFFF_0000);
        rd_lit("R1 fvec", 7'h44, 32'hFFFF_0000);
        for (int a = 0; a < 128; a += 4) rd("R1 reset map", 7'(a));

        // R10, R6, R2: source 3 through the low enable word
        wr(7'h14, 32'h0000_0008);
        src[3] = 1'b1;
        #1;
        check("R10 before edge", 32'(nirq), 32'd0);
        tick();
        check("R10 after edge", 32'(nirq), 32'd1);
        rd_lit("R6 single", 7'h40, 32'h0003_0000);
        rd_lit("R2 pend low", 7'h5C, 32'h0000_0008);
        rd_lit("R11 raw low", 7'h4C, 32'h0000_0008);

        // R3, R6 tie across halves
        wr(7'h10, 32'h1000_0000);
        src[60] = 1'b1;
        tick();
        rd_lit("R3 enable high", 7'h10, 32'h1000_0000);
        rd_lit("R6 tie higher number", 7'h40, 32'h003C_0000);

        // R5 reversed group placement
        wr(7'h3C, 32'h0000_5000);
        rd_lit("R5 source3 prio", 7'h40, 32'h0003_0005);
        wr(7'h20, 32'h0007_0000);
        rd_lit("R5 source60 prio", 7'h40, 32'h003C_0007);

        // R7 threshold boundaries
        wr(7'h04, 32'h0000_0007);
        rd_lit("R7 all blocked", 7'h40, 32'hFFFF_0000);
        check("R7 nirq low", 32'(nirq), 32'd0);
        wr(7'h04, 32'h0000_0006);
        rd_lit("R7 just above", 7'h40, 32'h003C_0007);
        wr(7'h04, 32'h0000_0005);
        rd_lit("R7 pend low blocked", 7'h5C, 32'h0000_0000);
        wr(7'h04, 32'h0000_0004);
        rd_lit("R7 both pass", 7'h5C, 32'h0000_0008);
        wr(7'h04, 32'h0000_0010);

        // R8 fast routing
        wr(7'h1C, 32'h0000_0008);
        rd_lit("R8 fvec", 7'h44, 32'h0003_0000);
        rd_lit("R2 fast low", 7'h64, 32'h0000_0008);
        wr(7'h18, 32'h1000_0000);
        rd_lit("R8 lowest fast", 7'h44, 32'h0003_0000);
        rd_lit("R6 no normal", 7'h40, 32'hFFFF_0000);
        wr(7'h1C, 32'h0);
        wr(7'h18, 32'h0);

        // R4 by-number enable
        src[40] = 1'b1;
        wr(7'h08, 32'd40);
        rd_lit("R4 set bit40", 7'h10, 32'h1000_0100);
        rd_lit("R4 reads zero", 7'h08, 32'h0);
        wr(7'h0C, 32'd40);
        rd_lit("R4 clear bit40", 7'h10, 32'h1000_0000);
        rd_lit("R4 disable reads zero", 7'h0C, 32'h0);

        // R2 force without input
        wr(7'h08, 32'd7);
        wr(7'h54, 32'h0000_0080);
        rd_lit("R2 forced pend", 7'h5C, 32'h0000_0088);
        rd_lit("R3 force readback", 7'h54, 32'h0000_0080);

        // R11 control, R12 misaligned/unmapped
        wr(7'h00, 32'hA5A5_0F0F);
        rd_lit("R11 control", 7'h00, 32'hA5A5_0F0F);
        wr(7'h01, 32'h1234_5678);
        rd_lit("R12 misaligned ignored", 7'h00, 32'hA5A5_0F0F);
        rd_lit("R12 misaligned read", 7'h01, 32'h0);
        wr(7'h6C, 32'hFFFF_FFFF);
        rd_lit("R12 unmapped", 7'h6C, 32'h0);

        // random phase checked against the model every clock (R2 R5 R6 R7 R8)
        for (int it = 0; it < 1500; it++) begin
            src = {$urandom, $urandom};
            if ($urandom_range(0, 2) != 0) begin
                int sel = $urandom_range(0, 25);
                logic [6:0]  a;
                logic [31:0] d = $urandom;
                if (sel < 18) a = 7'(sel * 4);
                else a = 7'(32'h40 + (sel - 18) * 4);
                if (sel == 1) d = 32'($urandom_range(0, 31));
                if ($urandom_range(0, 3) == 0) d = d & $urandom;
                wr(a, d);
            end else begin
                tick();
            end
            rd("R6 random nvec", 7'h40);
            rd("R8 random fvec", 7'h44);
            rd("R2 random map", 7'(4 * $urandom_range(0, 31)));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule